// File: doc/BRIEF.md
# Ethernet PHY management register file

This block holds the management registers of a 10/100 Ethernet PHY behind a plain parallel port: a register index, 16-bit write data, a write strobe, a read strobe and 16-bit read data. It keeps writable control, status, advertisement and interrupt-mask registers, plus a clear-on-read interrupt-source register. It also returns fixed identification, link-partner, expansion and special-status words. Serial management framing, real negotiation, loopback and power-down are not modelled. Negotiation is treated as finishing at once.

A link-up input is brought into the clock domain through a synchroniser chain. Each change of the synchronised level, the first cycle after reset and every software reset apply the current link state. Applying the state updates the status link and negotiation-done bits and raises interrupt-source bits. A level interrupt output is high whenever a source bit and its mask bit are both set.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After reset the status register (index 1) reads 0x7809, control (index 0) 0x3000, advertisement (index 4) 0x01E1, mask (index 30) 0x0000, and source (index 29) 0x0000. The first clock edge after reset applies the synchronised link level, so with the link down the source then reads 0x0010.
- R2: Applying a down link clears status bits 2 and 5 and sets source bit 4 (value 0x0010).
- R3: Applying an up link sets status bits 2 and 5 and sets source bits 6 and 7 (value 0x00C0). With SYNC_STAGES=2, the registers show this on the third clock edge after the input changes.
- R4: A write to index 0 with bit 15 set discards the written value. It restores every register to its reset value and then applies the current link level in the same edge.
- R5: Any other write to index 0 stores the data ANDed with 0x7980. If data bit 12 is set, status bit 5 is set at the same edge.
- R6: A write to index 4 stores (data AND 0x2D7F) OR 0x0080.
- R7: The fixed words read as follows: index 2 gives 0x0007, index 3 gives 0xC0D1, index 5 gives 0x0F71, index 6 gives 0x0001 and index 17 gives 0x0040.
- R8: A read of index 29 returns the source bits and clears them at the closing edge. The interrupt output drops after that edge.
- R9: A write to index 30 keeps only the low 8 data bits as the mask.
- R10: The interrupt output is high exactly when source AND mask is non-zero, one edge after either register changes.
- R11: Reads of unimplemented indices return 0. Writes to read-only or unimplemented indices have no effect. Read data is 0 while the read strobe is low.
- R12: If a read of index 29 and a link application fall on the same edge, the new event bits survive and only the older bits are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register index; the low 5 bits are decoded |
| reg_wdata | input | DATA_W | Write data |
| reg_we | input | 1 | Write strobe, one access per high cycle |
| reg_re | input | 1 | Read strobe; a read of index 29 clears the source |
| reg_rdata | output | DATA_W | Read data, combinational from index and strobe |
| link_up_in | input | 1 | Asynchronous link-up level |
| irq_out | output | 1 | Level interrupt |

## Verification
Read data is combinational, so the bench samples it 1 ns after driving the index and strobe on a falling edge. Register updates from a write or a clear-on-read become visible at the next falling edge, after one rising edge. Link changes need three rising edges at the default depth, so the bench drives the link input on a falling edge and waits three falling edges before reading. The interrupt output follows source and mask with one edge of delay and is sampled on the falling edge after the change. For the same-edge case, the read strobe is placed on the exact cycle in which the third rising edge lands.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
   // register indices whose decoding software relies on
   localparam logic [4:0] IDX_CTRL    = 5'd0;
   localparam logic [4:0] IDX_STAT    = 5'd1;
   localparam logic [4:0] IDX_ID_HI   = 5'd2;
   localparam logic [4:0] IDX_ID_LO   = 5'd3;
   localparam logic [4:0] IDX_ADV     = 5'd4;
   localparam logic [4:0] IDX_PARTNER = 5'd5;
   localparam logic [4:0] IDX_EXPN    = 5'd6;
   localparam logic [4:0] IDX_SPECIAL = 5'd17;
   localparam logic [4:0] IDX_ISRC    = 5'd29;
   localparam logic [4:0] IDX_IMASK   = 5'd30;

   localparam logic [15:0] CTRL_INIT   = 16'h3000;
   localparam logic [15:0] STAT_INIT   = 16'h7809;
   localparam logic [15:0] ADV_INIT    = 16'h01E1;
   localparam logic [15:0] CTRL_KEEP   = 16'h7980;
   localparam logic [15:0] ADV_KEEP    = 16'h2D7F;
   localparam logic [15:0] ADV_FORCED  = 16'h0080;
   localparam logic [15:0] WORD_ID_HI  = 16'h0007;
   localparam logic [15:0] WORD_ID_LO  = 16'hC0D1;
   localparam logic [15:0] WORD_PARTN  = 16'h0F71;
   localparam logic [15:0] WORD_EXPN   = 16'h0001;
   localparam logic [15:0] WORD_SPEC   = 16'h0040;

   localparam int CTRL_SWRST_BIT = 15;
   localparam int CTRL_ANEN_BIT  = 12;
   localparam int STAT_LINK_BIT  = 2;
   localparam int STAT_ANOK_BIT  = 5;

   // interrupt-source bit positions
   localparam int SRC_DOWN_BIT   = 4;
   localparam int SRC_ANOK_BIT   = 6;
   localparam int SRC_ENERGY_BIT = 7;
endpackage

// File: rtl/phy_link_sync.sv
module phy_link_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic link_async,
   input  logic soft_rst,
   output logic link_lvl,
   output logic apply
);
   localparam int TOP = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_depth
      $error("phy_link_sync: SYNC_STAGES must be at least 2");
   end

   logic [TOP:0] chain_q;
   logic         prev_q;
   logic         first_q;

   if (SYNC_STAGES == 2) begin : g_two
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[0], link_async};
      end
   end else begin : g_deep
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[TOP-1:0], link_async};
      end
   end

   assign link_lvl = chain_q[TOP];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         first_q <= 1'b1;
      end else begin
         prev_q  <= link_lvl;
         first_q <= 1'b0;
      end
   end

   assign apply = first_q | soft_rst | (link_lvl ^ prev_q);

   // R1
   first_apply_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      first_q |=> !first_q);
endmodule

// File: rtl/phy_irq_ctrl.sv
module phy_irq_ctrl
   import phy_mgmt_pkg::*;
#(
   parameter int MASK_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              apply,
   input  logic              link_lvl,
   input  logic              soft_rst,
   input  logic              src_clr,
   input  logic              mask_we,
   input  logic [MASK_W-1:0] mask_wdata,
   output logic [MASK_W-1:0] src_q,
   output logic [MASK_W-1:0] mask_q,
   output logic              irq
);
   if (MASK_W < 8 || MASK_W > 16) begin : g_bad_mask
      $error("phy_irq_ctrl: MASK_W must lie in 8..16");
   end

   logic [MASK_W-1:0] evt;
   logic [MASK_W-1:0] src_d;

   always_comb begin
      evt = '0;
      if (apply) begin
         if (link_lvl) begin
            evt[SRC_ANOK_BIT]   = 1'b1;
            evt[SRC_ENERGY_BIT] = 1'b1;
         end else begin
            evt[SRC_DOWN_BIT]   = 1'b1;
         end
      end
      if (soft_rst)     src_d = evt;
      else if (src_clr) src_d = evt;
      else              src_d = src_q | evt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= '0;
         mask_q <= '0;
      end else begin
         src_q <= src_d;
         if (soft_rst)     mask_q <= '0;
         else if (mask_we) mask_q <= mask_wdata;
      end
   end

   assign irq = |(src_q & mask_q);

   // R8
   read_clears_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_clr && !apply) |=> (src_q == '0));
   // R10
   zero_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_we && mask_wdata == '0) |=> !irq);
   // R2
   down_sets_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (apply && !link_lvl) |=> src_q[SRC_DOWN_BIT]);
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
   import phy_mgmt_pkg::*;
#(
   parameter int ADDR_W      = 5,
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2,
   parameter int IMASK_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_we,
   input  logic              reg_re,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              link_up_in,
   output logic              irq_out
);
   localparam int IDX_W = 5;

   if (DATA_W != 16) begin : g_bad_data
      $error("phy_mgmt_regs: DATA_W must be 16");
   end
   if (ADDR_W < IDX_W) begin : g_bad_addr
      $error("phy_mgmt_regs: ADDR_W must be at least 5");
   end

   // index is taken modulo 32
   logic [IDX_W-1:0] idx;
   assign idx = reg_addr[IDX_W-1:0];

   logic ctrl_we, soft_rst, adv_we, mask_we, src_clr;
   assign ctrl_we  = reg_we && (idx == IDX_CTRL);
   assign soft_rst = ctrl_we && reg_wdata[CTRL_SWRST_BIT];
   assign adv_we   = reg_we && (idx == IDX_ADV);
   assign mask_we  = reg_we && (idx == IDX_IMASK);
   assign src_clr  = reg_re && (idx == IDX_ISRC);

   logic link_lvl, apply;

   phy_link_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .link_async(link_up_in),
      .soft_rst  (soft_rst),
      .link_lvl  (link_lvl),
      .apply     (apply)
   );

   logic [IMASK_W-1:0] src_q, mask_q;

   phy_irq_ctrl #(.MASK_W(IMASK_W)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .apply     (apply),
      .link_lvl  (link_lvl),
      .soft_rst  (soft_rst),
      .src_clr   (src_clr),
      .mask_we   (mask_we),
      .mask_wdata(reg_wdata[IMASK_W-1:0]),
      .src_q     (src_q),
      .mask_q    (mask_q),
      .irq       (irq_out)
   );

   logic [DATA_W-1:0] ctrl_q, stat_q, adv_q, stat_d;

   always_comb begin
      stat_d = soft_rst ? STAT_INIT : stat_q;
      if (apply) begin
         stat_d[STAT_LINK_BIT] = link_lvl;
         stat_d[STAT_ANOK_BIT] = link_lvl;
      end
      // negotiation is deemed to finish at once
      if (ctrl_we && !soft_rst && reg_wdata[CTRL_ANEN_BIT])
         stat_d[STAT_ANOK_BIT] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_INIT;
         stat_q <= STAT_INIT;
         adv_q  <= ADV_INIT;
      end else begin
         stat_q <= stat_d;
         if (soft_rst) begin
            ctrl_q <= CTRL_INIT;
            adv_q  <= ADV_INIT;
         end else begin
            if (ctrl_we) ctrl_q <= reg_wdata & CTRL_KEEP;
            if (adv_we)  adv_q  <= (reg_wdata & ADV_KEEP) | ADV_FORCED;
         end
      end
   end

   logic [DATA_W-1:0] src_word, mask_word, rd_val;

   always_comb begin
      src_word  = '0;
      mask_word = '0;
      src_word[IMASK_W-1:0]  = src_q;
      mask_word[IMASK_W-1:0] = mask_q;
      case (idx)
         IDX_CTRL:    rd_val = ctrl_q;
         IDX_STAT:    rd_val = stat_q;
         IDX_ID_HI:   rd_val = WORD_ID_HI;
         IDX_ID_LO:   rd_val = WORD_ID_LO;
         IDX_ADV:     rd_val = adv_q;
         IDX_PARTNER: rd_val = WORD_PARTN;
         IDX_EXPN:    rd_val = WORD_EXPN;
         IDX_SPECIAL: rd_val = WORD_SPEC;
         IDX_ISRC:    rd_val = src_word;
         IDX_IMASK:   rd_val = mask_word;
         default:     rd_val = '0;
      endcase
   end

   assign reg_rdata = reg_re ? rd_val : '0;

   // R4
   soft_reset_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (ctrl_q == CTRL_INIT && adv_q == ADV_INIT));
   // R3
   link_up_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (apply && link_lvl) |=> (stat_q[STAT_LINK_BIT] && stat_q[STAT_ANOK_BIT]));
   // R5
   ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_we |=> $stable(ctrl_q));
endmodule

// File: tb/sim_phy_mgmt_regs.sv
`timescale 1ns/1ps
module sim_phy_mgmt_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic        reg_we = 1'b0;
   logic        reg_re = 1'b0;
   logic [15:0] reg_rdata;
   logic        link_up_in = 1'b0;
   logic        irq_out;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   phy_mgmt_regs u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_we    (reg_we),
      .reg_re    (reg_re),
      .reg_rdata (reg_rdata),
      .link_up_in(link_up_in),
      .irq_out   (irq_out)
   );

   // {write, index, data, expected read, requirement number}
   localparam int NV = 25;
   localparam logic [41:0] VEC [0:NV-1] = '{
      {1'b0, 5'd2,  16'h0000, 16'h0007, 4'd7},   // R7
      {1'b0, 5'd3,  16'h0000, 16'hC0D1, 4'd7},   // R7
      {1'b0, 5'd5,  16'h0000, 16'h0F71, 4'd7},   // R7
      {1'b0, 5'd6,  16'h0000, 16'h0001, 4'd7},   // R7
      {1'b0, 5'd17, 16'h0000, 16'h0040, 4'd7},   // R7
      {1'b0, 5'd9,  16'h0000, 16'h0000, 4'd11},  // R11
      {1'b1, 5'd4,  16'hFFFF, 16'h0000, 4'd6},
      {1'b0, 5'd4,  16'h0000, 16'h2DFF, 4'd6},   // R6
      {1'b1, 5'd4,  16'h0000, 16'h0000, 4'd6},
      {1'b0, 5'd4,  16'h0000, 16'h0080, 4'd6},   // R6
      {1'b1, 5'd0,  16'h00FF, 16'h0000, 4'd5},
      {1'b0, 5'd0,  16'h0000, 16'h0080, 4'd5},   // R5
      {1'b0, 5'd1,  16'h0000, 16'h7809, 4'd5},   // R5
      {1'b1, 5'd0,  16'h1000, 16'h0000, 4'd5},
      {1'b0, 5'd1,  16'h0000, 16'h7829, 4'd5},   // R5
      {1'b1, 5'd30, 16'hABCD, 16'h0000, 4'd9},
      {1'b0, 5'd30, 16'h0000, 16'h00CD, 4'd9},   // R9
      {1'b1, 5'd2,  16'h1234, 16'h0000, 4'd11},
      {1'b0, 5'd2,  16'h0000, 16'h0007, 4'd11},  // R11
      {1'b1, 5'd0,  16'h8000, 16'h0000, 4'd4},
      {1'b0, 5'd0,  16'h0000, 16'h3000, 4'd4},   // R4
      {1'b0, 5'd1,  16'h0000, 16'h7809, 4'd4},   // R4
      {1'b0, 5'd4,  16'h0000, 16'h01E1, 4'd4},   // R4
      {1'b0, 5'd30, 16'h0000, 16'h0000, 4'd4},   // R4
      {1'b0, 5'd29, 16'h0000, 16'h0010, 4'd4}    // R4
   };

   task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [15:0] v);
      reg_addr = a; reg_re = 1'b1;
      #1 v = reg_rdata;
      @(negedge clk);
      reg_re = 1'b0;
   endtask

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #4_000_000;
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] v;
      wait_n(3);
      rst_n = 1'b1;
      // R1 reset state, read before the first edge out of reset
      check("R1 irq", {15'd0, irq_out}, 16'h0000);
      rd(5'd29, v); check("R1 src", v, 16'h0000);
      rd(5'd1, v);  check("R1 stat", v, 16'h7809);
      rd(5'd0, v);  check("R1 ctrl", v, 16'h3000);
      rd(5'd4, v);  check("R1 adv", v, 16'h01E1);
      rd(5'd30, v); check("R1 mask", v, 16'h0000);
      rd(5'd29, v); check("R1 link applied", v, 16'h0010);

      for (int k = 0; k < NV; k++) begin
         if (VEC[k][41]) begin
            wr(VEC[k][40:36], VEC[k][35:20]);
         end else begin
            rd(VEC[k][40:36], v);
            checks++;
            if (v !== VEC[k][19:4]) begin
               errors++;
               $display("FAIL R%0d vector %0d got %h expected %h", VEC[k][3:0], k, v, VEC[k][19:4]);
            end
         end
      end

      // R3 link rises: three edges to reach the registers
      link_up_in = 1'b1;
      wait_n(3);
      rd(5'd1, v);  check("R3 stat", v, 16'h782D);
      rd(5'd29, v); check("R3 src", v, 16'h00C0);

      // R10 masked-off source keeps irq low, matching mask raises it
      wr(5'd30, 16'h0080);
      link_up_in = 1'b0;
      wait_n(3);
      check("R10 masked", {15'd0, irq_out}, 16'h0000);
      wr(5'd30, 16'h0010);
      check("R10 raised", {15'd0, irq_out}, 16'h0001);
      rd(5'd1, v);  check("R2 stat", v, 16'h7809);
      rd(5'd29, v); check("R8 src", v, 16'h0010);
      check("R8 irq low", {15'd0, irq_out}, 16'h0000);
      rd(5'd29, v); check("R8 cleared", v, 16'h0000);

      // R4 soft reset while link is up reapplies the up state
      link_up_in = 1'b1;
      wait_n(3);
      rd(5'd29, v); check("R3 src again", v, 16'h00C0);
      wr(5'd0, 16'h8000);
      rd(5'd1, v);  check("R4 stat up", v, 16'h782D);
      rd(5'd0, v);  check("R4 ctrl", v, 16'h3000);
      rd(5'd30, v); check("R4 mask", v, 16'h0000);
      rd(5'd29, v); check("R4 src", v, 16'h00C0);

      // R12 clear-on-read meets a link event on the same edge
      wr(5'd0, 16'h8000);
      link_up_in = 1'b0;
      wait_n(2);
      rd(5'd29, v); check("R12 old", v, 16'h00C0);
      rd(5'd29, v); check("R12 new kept", v, 16'h0010);
      rd(5'd1, v);  check("R2 stat again", v, 16'h7809);

      // R11 read data stays zero without the read strobe
      reg_addr = 5'd2; reg_re = 1'b0;
      #1 check("R11 no strobe", reg_rdata, 16'h0000);
      @(negedge clk);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule